// File: doc/BRIEF.md
# I/O Glue Register and Tick Interrupt Latch

This block sits on a 32-bit processor bus and answers at three word locations inside its address window. A write to the control location loads a 4-bit register from data bits 19:16. That register sets the polarity of the horizontal and vertical sync outputs and picks which of three video clock inputs is passed to the clock output. A read of the identification location returns a fixed byte. A read of the acknowledge location clears the tick interrupt latch and restarts the tick period.

The interrupt latch is set by a rising edge. The edge can come from the external interrupt pin, which passes through a two-flop synchronizer first, or from the block's own one-shot tick timer. The timer expires once every `TICK_DIV` clock cycles after reset or after an acknowledge, and then waits to be re-armed. At an 8 MHz clock the default of 4096 gives a 1953.125 Hz tick. The latch drives an active-low interrupt line that stays low until an acknowledge read or a reset clears it.

Top module: `ioglue_top`

## Requirements
- R1: A write strobe at byte offset 0x48 loads the control register from data bits 19:16. Data bit 16 goes to register bit 0 and data bit 19 to register bit 3. A read at 0x48 returns 0xFFFFFFFF one cycle after the strobe.
- R2: After reset the control register is 0, `irq_n` is 1, `rd_data` is 0, the vertical sync output is the inverted input, the horizontal sync output follows its input, and the clock output carries the 24 MHz input.
- R3: Control bit 3 = 1 passes `vsync_in` to `vsync_out` unchanged. Bit 3 = 0 inverts it.
- R4: Control bit 2 = 0 passes `hsync_in` to `hsync_out` unchanged. Bit 2 = 1 inverts it.
- R5: Control bits 1:0 select `vclk_out` as follows: 00 gives `vclk_24_in`, 01 gives `vclk_25_in`, 10 gives `vclk_36_in`, and 11 gives `vclk_24_in`.
- R6: A rising edge on `ext_irq_in` that is present before clock edge N sets the latch at edge N+2, so `irq_n` is 0 after that edge.
- R7: A read strobe at byte offset 0x58 clears the latch at that clock edge, unless a set arrives in the same cycle. The read returns 0xFFFFFFFF in `rd_data` in the following cycle.
- R8: A read strobe at byte offset 0x50 returns 0x000000F5 in `rd_data` in the following cycle.
- R9: The tick timer sets the latch at the `TICK_DIV`-th clock edge after reset release or after an acknowledge edge. It then stays idle until the next acknowledge re-arms it.
- R10: If a set (external edge or tick) and an acknowledge fall on the same edge, the latch ends up set.
- R11: Write or read strobes at any offset other than 0x48, 0x50 and 0x58 leave the control register and the latch unchanged, and such reads return 0. Without a read strobe, `rd_data` is 0.
- R12: Holding `ext_irq_in` high does not set the latch again after it has been acknowledged. Only a new low-to-high transition does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte offset within the peripheral window |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Registered read data, valid the cycle after a read strobe |
| hsync_in | input | 1 | Horizontal sync from the video controller |
| vsync_in | input | 1 | Composite/vertical sync from the video controller |
| hsync_out | output | 1 | Horizontal sync after polarity control |
| vsync_out | output | 1 | Vertical sync after polarity control |
| vclk_24_in | input | 1 | 24 MHz video clock source |
| vclk_25_in | input | 1 | 25 MHz video clock source |
| vclk_36_in | input | 1 | 36 MHz video clock source |
| vclk_out | output | 1 | Selected video clock |
| ext_irq_in | input | 1 | Asynchronous external interrupt request, rising-edge sensitive |
| irq_n | output | 1 | Active-low latched interrupt |

## Verification
Two events can fall on the same clock edge: a set of the latch and an acknowledge that clears it. The set can come from a synchronized pin edge or from tick expiry. The bench sweeps the delay between raising `ext_irq_in` and issuing the acknowledge read over several cycles, so one of the delays lands on the exact edge where the synchronized rise appears. It also sweeps acknowledge reads across the cycles around tick expiry. A behavioural model, clocked alongside the design, decides the expected state of `irq_n` at every edge, and a latch that reads high after any coincident edge is counted as a miscompare.

// File: rtl/ioglue_pkg.sv
package ioglue_pkg;

  // Byte offsets decoded inside the peripheral window
  localparam logic [7:0] OFS_CTRL = 8'h48;
  localparam logic [7:0] OFS_ID   = 8'h50;
  localparam logic [7:0] OFS_ACK  = 8'h58;

  // Fixed identification byte
  localparam logic [7:0] ID_BYTE  = 8'hF5;

  // Lowest data bit carrying the control field
  localparam int unsigned CTRL_LSB = 16;
  localparam int unsigned CTRL_W   = 4;

  typedef enum logic [1:0] {
    VCLK_SEL_24A = 2'b00,
    VCLK_SEL_25  = 2'b01,
    VCLK_SEL_36  = 2'b10,
    VCLK_SEL_24B = 2'b11
  } vclk_sel_e;

  // Bit 3: vertical pass-through, bit 2: horizontal invert, bits 1:0: clock select
  typedef struct packed {
    logic      vsync_pass;
    logic      hsync_inv;
    vclk_sel_e clk_sel;
  } ctrl_t;

endpackage

// File: rtl/ioglue_bus_decode.sv
module ioglue_bus_decode
  import ioglue_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] rd_data,
  output logic              ack_strobe
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(OFS_ID);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFS_ACK);
  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] ID_WORD  = DATA_W'(ID_BYTE);

  logic              hit_ctrl, hit_id, hit_ack;
  logic              ctrl_en;
  ctrl_t             ctrl_q, ctrl_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    hit_ctrl = (bus_addr == A_CTRL);
    hit_id   = (bus_addr == A_ID);
    hit_ack  = (bus_addr == A_ACK);
  end

  // Control register next state with explicit enable
  always_comb begin
    ctrl_en = bus_wr && hit_ctrl;
    ctrl_d  = ctrl_q;
    if (ctrl_en) begin
      ctrl_d = ctrl_t'(bus_wdata[CTRL_LSB +: CTRL_W]);
    end
  end

  // Read data next state: zero when no read strobe
  always_comb begin
    rdata_d = '0;
    if (bus_rd) begin
      if (hit_id) begin
        rdata_d = ID_WORD;
      end else if (hit_ctrl || hit_ack) begin
        rdata_d = ALL_ONES;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign ctrl       = ctrl_q;
  assign rd_data    = rdata_q;
  assign ack_strobe = bus_rd && hit_ack;

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL) |=> (ctrl == $past(bus_wdata[CTRL_LSB +: CTRL_W]))); // R1

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_CTRL) |=> $stable(ctrl)); // R11

  AST_ID_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_ID) |=> (rd_data == ID_WORD)); // R8

  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (rd_data == '0)); // R11

endmodule

// File: rtl/ioglue_video_out.sv
module ioglue_video_out
  import ioglue_pkg::*;
#(
  parameter int unsigned NUM_SYNC = 2
) (
  input  ctrl_t ctrl,
  input  logic  hsync_in,
  input  logic  vsync_in,
  input  logic  vclk_24_in,
  input  logic  vclk_25_in,
  input  logic  vclk_36_in,
  output logic  hsync_out,
  output logic  vsync_out,
  output logic  vclk_out
);

  logic [NUM_SYNC-1:0] sync_raw;
  logic [NUM_SYNC-1:0] sync_flip;
  logic [NUM_SYNC-1:0] sync_fixed;

  // Channel 0 horizontal, channel 1 vertical (vertical flips when its bit is clear)
  always_comb begin
    sync_raw     = '0;
    sync_flip    = '0;
    sync_raw[0]  = hsync_in;
    sync_raw[1]  = vsync_in;
    sync_flip[0] = ctrl.hsync_inv;
    sync_flip[1] = ~ctrl.vsync_pass;
  end

  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_pol
    assign sync_fixed[g] = sync_raw[g] ^ sync_flip[g];
  end

  assign hsync_out = sync_fixed[0];
  assign vsync_out = sync_fixed[1];

  always_comb begin
    unique case (ctrl.clk_sel)
      VCLK_SEL_25:  vclk_out = vclk_25_in;
      VCLK_SEL_36:  vclk_out = vclk_36_in;
      VCLK_SEL_24A,
      VCLK_SEL_24B: vclk_out = vclk_24_in;
      default:      vclk_out = vclk_24_in;
    endcase
  end

endmodule

// File: rtl/ioglue_tick_irq.sv
module ioglue_tick_irq #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TICK_DIV    = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_irq_in,
  input  logic ack,
  output logic irq_n
);

  localparam int unsigned CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

  // Synchronizer chain plus one history flop for edge detection
  logic [SYNC_STAGES:0] sync_q;
  logic                 ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-1:0], ext_irq_in};
    end
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  // One-shot tick timer, re-armed by acknowledge
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             tick_fire;
  logic             tmr_en;

  assign tick_fire = armed_q && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    tmr_en  = ack || armed_q;
    if (ack) begin
      cnt_d   = '0;
      armed_d = 1'b1;
    end else if (tick_fire) begin
      cnt_d   = '0;
      armed_d = 1'b0;
    end else if (armed_q) begin
      cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (tmr_en) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  // Interrupt latch: set beats clear
  logic latch_q, latch_d;
  logic set_req;

  always_comb begin
    set_req = ext_rise || tick_fire;
    latch_d = latch_q;
    if (set_req) begin
      latch_d = 1'b1;
    end else if (ack) begin
      latch_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
    end else begin
      latch_q <= latch_d;
    end
  end

  assign irq_n = ~latch_q;

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !irq_n); // R6

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ext_rise && !tick_fire) |=> irq_n); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ext_rise) |=> !irq_n); // R10

  AST_TICK_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fire |=> !tick_fire); // R9

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n && !ext_rise && !tick_fire) |=> irq_n); // R12

endmodule

// File: rtl/ioglue_top.sv
module ioglue_top
  import ioglue_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TICK_DIV    = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              hsync_in,
  input  logic              vsync_in,
  output logic              hsync_out,
  output logic              vsync_out,
  input  logic              vclk_24_in,
  input  logic              vclk_25_in,
  input  logic              vclk_36_in,
  output logic              vclk_out,
  input  logic              ext_irq_in,
  output logic              irq_n
);

  ctrl_t ctrl;
  logic  ack_strobe;

  ioglue_bus_decode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .ctrl       (ctrl),
    .rd_data    (rd_data),
    .ack_strobe (ack_strobe)
  );

  ioglue_video_out #(
    .NUM_SYNC (2)
  ) u_video (
    .ctrl       (ctrl),
    .hsync_in   (hsync_in),
    .vsync_in   (vsync_in),
    .vclk_24_in (vclk_24_in),
    .vclk_25_in (vclk_25_in),
    .vclk_36_in (vclk_36_in),
    .hsync_out  (hsync_out),
    .vsync_out  (vsync_out),
    .vclk_out   (vclk_out)
  );

  ioglue_tick_irq #(
    .SYNC_STAGES (SYNC_STAGES),
    .TICK_DIV    (TICK_DIV)
  ) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_irq_in (ext_irq_in),
    .ack        (ack_strobe),
    .irq_n      (irq_n)
  );

endmodule

// File: tb/ioglue_top_tb_top.sv
module ioglue_top_tb_top;

  localparam int TDIV = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data;
  logic        hsync_in = 1'b0, vsync_in = 1'b0;
  logic        hsync_out, vsync_out;
  logic        vclk_24_in = 1'b0, vclk_25_in = 1'b0, vclk_36_in = 1'b0;
  logic        vclk_out;
  logic        ext_irq_in = 1'b0;
  logic        irq_n;

  always #10 clk = ~clk;

  ioglue_top #(.TICK_DIV(TDIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .hsync_out(hsync_out), .vsync_out(vsync_out), .vclk_24_in(vclk_24_in),
    .vclk_25_in(vclk_25_in), .vclk_36_in(vclk_36_in), .vclk_out(vclk_out),
    .ext_irq_in(ext_irq_in), .irq_n(irq_n)
  );

  int    vectors = 0;
  int    errors  = 0;
  int    cycles  = 0;
  bit    done    = 0;
  string cur_req = "R2";

  // Behavioural reference state
  int m_ctrl, m_latch, m_cnt, m_armed, m_s1, m_s2, m_s3;
  int unsigned m_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_latch = 0; m_cnt = 0; m_armed = 1;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_rdata = 0;
    end else begin
      bit rise, fire, ack;
      rise = (m_s2 == 1) && (m_s3 == 0);
      fire = (m_armed == 1) && (m_cnt == TDIV - 1);
      ack  = bus_rd && (bus_addr == 8'h58);
      if (bus_rd && bus_addr == 8'h50) m_rdata = 32'hF5;
      else if (bus_rd && (bus_addr == 8'h48 || bus_addr == 8'h58)) m_rdata = 32'hFFFF_FFFF;
      else m_rdata = 0;
      if (bus_wr && bus_addr == 8'h48) m_ctrl = int'(bus_wdata[19:16]);
      if (rise || fire) m_latch = 1;
      else if (ack) m_latch = 0;
      if (ack) begin m_cnt = 0; m_armed = 1; end
      else if (fire) begin m_cnt = 0; m_armed = 0; end
      else if (m_armed == 1) m_cnt = m_cnt + 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(ext_irq_in);
    end
  end

  task automatic cmp(input string what, input int unsigned act, input int unsigned exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", cur_req, what, act, exp, cycles);
    end
  endtask

  // Compare all outputs at every falling edge, before inputs move
  always @(negedge clk) begin
    if (!done) begin
      int sel;
      bit exp_clk;
      sel = m_ctrl & 3;
      exp_clk = (sel == 1) ? vclk_25_in : (sel == 2) ? vclk_36_in : vclk_24_in;
      cmp("irq_n (R6 R7 R9 R10 R12)", int'(irq_n), (m_latch == 1) ? 0 : 1);
      cmp("rd_data (R1 R7 R8 R11)", rd_data, m_rdata);
      cmp("hsync_out (R4)", int'(hsync_out), int'(hsync_in) ^ ((m_ctrl >> 2) & 1));
      cmp("vsync_out (R3)", int'(vsync_out), int'(vsync_in) ^ (((m_ctrl >> 3) & 1) ^ 1));
      cmp("vclk_out (R5)", int'(vclk_out), int'(exp_clk));
    end
  end

  // Free-running video-side stimulus
  int unsigned pat = 32'h1357_9BDF;
  always @(negedge clk) begin
    #2;
    pat = pat ^ (pat << 13); pat = pat ^ (pat >> 17); pat = pat ^ (pat << 5);
    hsync_in   = pat[0];
    vsync_in   = pat[3];
    vclk_24_in = pat[7];
    vclk_25_in = pat[11];
    vclk_36_in = pat[19];
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); #2;
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a);
    @(negedge clk); #2;
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); #2;
    bus_rd = 1'b0;
  endtask

  task automatic set_ext(input logic v);
    @(negedge clk); #2;
    ext_irq_in = v;
  endtask

  initial begin
    cur_req = "R2";
    idle(4);
    @(negedge clk); #2; rst_n = 1'b1;
    idle(6);

    cur_req = "R8";
    bus_read(8'h50);
    idle(2);
    bus_read(8'h50);

    cur_req = "R1";
    for (int v = 0; v < 16; v++) begin
      bus_write(8'h48, (32'(v) << 16) | 32'hFFF0_FFFF ^ 32'(v * 32'h0101_0101 & 32'hFFF0_FFFF));
      idle(3);
    end
    bus_read(8'h48);

    cur_req = "R3";
    bus_write(8'h48, 32'h0008_0000); idle(8);
    cur_req = "R4";
    bus_write(8'h48, 32'h0004_0000); idle(8);
    cur_req = "R5";
    for (int s = 0; s < 4; s++) begin
      bus_write(8'h48, 32'(s) << 16); idle(10);
    end

    cur_req = "R11";
    bus_write(8'h48, 32'h000A_0000);
    bus_write(8'h4C, 32'h0005_0000);
    bus_write(8'h44, 32'h000F_0000);
    bus_write(8'h58, 32'h0003_0000);
    bus_read(8'h54);
    bus_read(8'h00);
    bus_read(8'h5C);
    idle(4);

    // Clear any pending tick before edge tests
    cur_req = "R7";
    bus_read(8'h58);
    idle(3);

    cur_req = "R6";
    set_ext(1'b1);
    idle(6);
    cur_req = "R7";
    bus_read(8'h58);
    cur_req = "R12";
    idle(12);
    bus_read(8'h58);
    idle(6);
    set_ext(1'b0);
    idle(4);

    cur_req = "R10";
    for (int d = 0; d < 5; d++) begin
      set_ext(1'b1);
      idle(d);
      bus_read(8'h58);
      idle(4);
      set_ext(1'b0);
      idle(4);
      bus_read(8'h58);
      idle(2);
    end

    cur_req = "R9";
    bus_read(8'h58);
    idle(TDIV + 8);
    for (int k = TDIV - 4; k < TDIV + 2; k++) begin
      bus_read(8'h58);
      idle(k - 1);
    end
    bus_read(8'h58);
    idle(2 * TDIV + 4);

    cur_req = "R2";
    @(negedge clk); #2; rst_n = 1'b0;
    idle(3);
    @(negedge clk); #2; rst_n = 1'b1;
    idle(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule